// File: doc/BRIEF.md
# Dual-Page CPU Bank Mapper

This block takes a CPU memory address and decides whether it falls in the 64 KB legacy graphics window at A0000h-AFFFFh. For an address in the window it produces a 20-bit display-memory address. Extended paging is switched on by a control bit. While it is off, the window offset passes straight through. While it is on, a bank number taken from a map register is scaled to a base address, and the window offset, optionally divided by two or by four, is added to that base.

There are two map registers, a low map and a high map. In single-page mode the low map serves the whole window. In dual-page mode, CPU address bit 15 picks the register: the lower 32 KB half uses the low map and the upper half uses the high map, each with a 15-bit page offset. A granularity bit sets the bank unit to 4 KB or 1 KB.

Software programs the control register and the two map registers through a small write/read port. Each access presented on the CPU side gives one registered result on the following cycle.

Top module: `bank_window_xlate`

## Requirements
- R1: One cycle after an access, `xl_hit` is 1 exactly when CPU address bits 19:16 equal hex A.
- R2: With control bit 0 (paging enable) clear, the translated address is the CPU address with bits 19:16 forced to zero.
- R3: With paging enabled, dual-page (control bit 1) clear and coarse granularity, the result is (low map << 12) + CPU address bits 15:0.
- R4: In dual-page mode, an address with bit 15 clear uses the low map and page offset CPU bits 14:0.
- R5: In dual-page mode, an address with bit 15 set uses the high map and page offset CPU bits 14:0.
- R6: Control bit 2 divides the offset by four (right shift by 2) before it is added.
- R7: Control bit 3, with bit 2 clear, divides the offset by two (right shift by 1).
- R8: When control bits 2 and 3 are both set, only the divide-by-four applies.
- R9: Control bit 4 selects 1 KB bank units, so the base is map << 10 instead of map << 12.
- R10: The sum of base and offset wraps modulo 2^20.
- R11: Register select 0 is control, 1 is low map and 2 is high map. Reading a register returns the last value written to it. Select 3 reads zero, and a write to it changes no register.
- R12: `xl_valid` follows `cpu_valid` one cycle later. A register write applies to an access presented in the very next cycle.
- R13: After reset all three registers read zero and `xl_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 low map, 2 high map |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cpu_valid | input | 1 | An access is presented this cycle |
| cpu_addr | input | 20 | CPU memory address |
| xl_valid | output | 1 | Registered result is present |
| xl_hit | output | 1 | The access fell inside the graphics window |
| xl_addr | output | 20 | Translated display-memory address |

## Verification
The clocked properties assume `reg_sel` and `cpu_addr` hold known values at every sampling edge, and that a register write and the access that relies on it are not given in the same cycle. The readback property also assumes the select line is held steady across the check. The bench drives all inputs on the falling edge, keeps an access and a register write in separate cycles, and holds the select line fixed through each read. As a result, every value sampled at a rising edge is settled and consistent with the model the bench keeps of the registers.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [2:0] spare;
    logic       fine;
    logic       div2;
    logic       div4;
    logic       dual;
    logic       en;
  } ctrl_t;

endpackage

// File: rtl/bwx_regs.sv
module bwx_regs
  import bwx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] map_lo,
  output logic [DATA_W-1:0] map_hi,
  output logic [DATA_W-1:0] rdata
);

  localparam int NUM_MAPS = 2;

  logic [DATA_W-1:0] map_q [NUM_MAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_en && sel == SEL_CTRL)
      ctrl_q <= wdata;
  end

  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        map_q[g] <= '0;
      else if (wr_en && sel == 2'(g + 1))
        map_q[g] <= wdata;
    end
  end

  assign map_lo = map_q[0];
  assign map_hi = map_q[1];

  always_comb begin
    unique case (sel)
      SEL_CTRL: rdata = ctrl_q;
      SEL_LOW:  rdata = map_q[0];
      SEL_HIGH: rdata = map_q[1];
      default:  rdata = '0;
    endcase
  end

  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(sel) == sel && sel != SEL_NONE) |-> rdata == $past(wdata)); // R11

  AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> rdata == '0); // R11

endmodule

// File: rtl/bwx_xlate.sv
module bwx_xlate
  import bwx_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int WIN_W    = 16,
  parameter int BANK_W   = 8,
  parameter int WIN_TAG  = 10,
  parameter int COARSE_SH = 12,
  parameter int FINE_SH   = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic              dual,
  input  logic              div4,
  input  logic              div2,
  input  logic              fine,
  input  logic [BANK_W-1:0] map_lo,
  input  logic [BANK_W-1:0] map_hi,
  output logic              hit,
  output logic              sel_high,
  output logic [ADDR_W-1:0] phys
);

  localparam int TAG_W = ADDR_W - WIN_W;

  function automatic logic [WIN_W-1:0] scale_off(input logic [WIN_W-1:0] o,
                                                 input logic d4, input logic d2);
    if (d4)      return o >> 2;
    else if (d2) return o >> 1;
    else         return o;
  endfunction

  function automatic logic [ADDR_W-1:0] bank_base(input logic [BANK_W-1:0] b,
                                                  input logic f);
    logic [ADDR_W-1:0] w;
    w = ADDR_W'(b);
    return f ? (w << FINE_SH) : (w << COARSE_SH);
  endfunction

  logic [TAG_W-1:0]  tag;
  logic [WIN_W-1:0]  raw_off;
  logic [WIN_W-1:0]  scaled_off;
  logic [BANK_W-1:0] bank;

  assign tag      = addr[ADDR_W-1:WIN_W];
  assign hit      = (tag == TAG_W'(WIN_TAG));
  assign sel_high = dual & addr[WIN_W-1];
  assign bank     = sel_high ? map_hi : map_lo;
  assign raw_off  = dual ? {1'b0, addr[WIN_W-2:0]} : addr[WIN_W-1:0];
  assign scaled_off = scale_off(raw_off, div4, div2);

  always_comb begin
    if (en)
      phys = bank_base(bank, fine) + ADDR_W'(scaled_off);
    else
      phys = ADDR_W'(addr[WIN_W-1:0]);
  end

endmodule

// File: rtl/bank_window_xlate.sv
module bank_window_xlate
  import bwx_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int WIN_W     = 16,
  parameter int DATA_W    = 8,
  parameter int WIN_TAG   = 10,
  parameter int COARSE_SH = 12,
  parameter int FINE_SH   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              xl_valid,
  output logic              xl_hit,
  output logic [ADDR_W-1:0] xl_addr
);

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] map_lo;
  logic [DATA_W-1:0] map_hi;
  ctrl_t             ctl;
  logic              nxt_hit;
  logic              nxt_sel_high;
  logic [ADDR_W-1:0] nxt_phys;
  logic [2:0]        unused_spare;

  assign ctl          = ctrl_t'(ctrl_q);
  assign unused_spare = ctl.spare;

  bwx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .sel    (reg_sel),
    .wdata  (reg_wdata),
    .ctrl_q (ctrl_q),
    .map_lo (map_lo),
    .map_hi (map_hi),
    .rdata  (reg_rdata)
  );

  bwx_xlate #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .BANK_W(DATA_W), .WIN_TAG(WIN_TAG),
    .COARSE_SH(COARSE_SH), .FINE_SH(FINE_SH)
  ) u_xlate (
    .addr     (cpu_addr),
    .en       (ctl.en),
    .dual     (ctl.dual),
    .div4     (ctl.div4),
    .div2     (ctl.div2),
    .fine     (ctl.fine),
    .map_lo   (map_lo),
    .map_hi   (map_hi),
    .hit      (nxt_hit),
    .sel_high (nxt_sel_high),
    .phys     (nxt_phys)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_valid <= 1'b0;
      xl_hit   <= 1'b0;
      xl_addr  <= '0;
    end else begin
      xl_valid <= cpu_valid;
      if (cpu_valid) begin
        xl_hit  <= nxt_hit;
        xl_addr <= nxt_phys;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |=> xl_valid); // R12

  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |=> !xl_valid); // R12

  AST_HIT_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |=> xl_hit == ($past(cpu_addr[ADDR_W-1:WIN_W]) == (ADDR_W-WIN_W)'(WIN_TAG))); // R1

  AST_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !ctl.en) |=> xl_addr == ADDR_W'($past(cpu_addr[WIN_W-1:0]))); // R2

  AST_HIGH_ONLY_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_sel_high |-> (ctl.dual && cpu_addr[WIN_W-1])); // R5

  AST_COARSE_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && ctl.en && !ctl.div4 && !ctl.div2 && !ctl.fine)
      |=> xl_addr[COARSE_SH-1:0] == $past(cpu_addr[COARSE_SH-1:0])); // R3

endmodule

// File: tb/bank_window_xlate_bench.sv
module bank_window_xlate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        cpu_valid = 1'b0;
  logic [19:0] cpu_addr = 20'd0;
  logic        xl_valid;
  logic        xl_hit;
  logic [19:0] xl_addr;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0] m_ctrl = 8'd0;
  logic [7:0] m_lo = 8'd0;
  logic [7:0] m_hi = 8'd0;

  logic [20:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  bank_window_xlate u_bank_window_xlate (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_valid(cpu_valid),
    .cpu_addr(cpu_addr), .xl_valid(xl_valid), .xl_hit(xl_hit), .xl_addr(xl_addr)
  );

  function automatic logic [20:0] model(input logic [19:0] a);
    logic        h;
    logic [19:0] base;
    logic [15:0] off;
    logic [7:0]  bk;
    h = (a[19:16] == 4'hA);
    if (!m_ctrl[0]) return {h, 4'h0, a[15:0]};
    if (m_ctrl[1]) begin
      bk  = a[15] ? m_hi : m_lo;
      off = {1'b0, a[14:0]};
    end else begin
      bk  = m_lo;
      off = a[15:0];
    end
    if (m_ctrl[2])      off = off / 16'd4;
    else if (m_ctrl[3]) off = off / 16'd2;
    base = m_ctrl[4] ? ({12'd0, bk} * 20'd1024) : ({12'd0, bk} * 20'd4096);
    return {h, base + {4'h0, off}};
  endfunction

  task automatic access(input logic [19:0] a, input string tag);
    @(negedge clk);
    reg_wr    = 1'b0;
    cpu_valid = 1'b1;
    cpu_addr  = a;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_valid = 1'b0;
    reg_wr    = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cpu_valid = 1'b0;
    reg_wr    = 1'b1;
    reg_sel   = s;
    reg_wdata = d;
    case (s)
      2'd0: m_ctrl = d;
      2'd1: m_lo   = d;
      2'd2: m_hi   = d;
      default: ;
    endcase
  endtask

  task automatic rd_check(input logic [1:0] s, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cpu_valid = 1'b0;
    reg_wr    = 1'b0;
    reg_sel   = s;
    #1;
    vectors++;
    if (reg_rdata !== exp) begin
      miscompares++;
      $display("FAIL %s: reg %0d read %h expected %h", tag, s, reg_rdata, exp);
    end
  endtask

  // Monitor: pops one expected item per produced result
  always @(negedge clk) begin
    if (rst_n && xl_valid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL R12: unexpected result hit=%b addr=%h expected none", xl_hit, xl_addr);
      end else begin
        logic [20:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (xl_hit !== e[20] || (e[20] && xl_addr !== e[19:0])) begin
          miscompares++;
          $display("FAIL %s: hit=%b addr=%h expected hit=%b addr=%h",
                   t, xl_hit, xl_addr, e[20], e[19:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    @(negedge clk);
    vectors++;
    if (xl_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R13: xl_valid=%b expected 0", xl_valid);
    end
    rd_check(2'd0, 8'h00, "R13");
    rd_check(2'd1, 8'h00, "R13");
    rd_check(2'd2, 8'h00, "R13");

    // R1, R2 paging disabled
    access(20'hA1234, "R2");
    access(20'hAFFFF, "R2");
    access(20'hB0000, "R1");
    access(20'h9FFFF, "R1");
    idle();

    // R3 single page, coarse
    wr_reg(2'd1, 8'h05);
    wr_reg(2'd0, 8'h01);
    access(20'hA1234, "R3");
    access(20'hAC000, "R3");
    access(20'hC1234, "R1");

    // R4, R5 dual page
    wr_reg(2'd1, 8'h10);
    wr_reg(2'd2, 8'h20);
    wr_reg(2'd0, 8'h03);
    access(20'hA1234, "R4");
    access(20'hA7FFF, "R4");
    access(20'hA9234, "R5");
    access(20'hA8000, "R5");

    // R6, R7, R8 scaling in single page
    wr_reg(2'd0, 8'h05);
    access(20'hA8000, "R6");
    access(20'hA0007, "R6");
    wr_reg(2'd0, 8'h09);
    access(20'hA8001, "R7");
    wr_reg(2'd0, 8'h0D);
    access(20'hAFFFF, "R8");
    wr_reg(2'd0, 8'h0F);
    access(20'hAFFFF, "R8");

    // R9 fine granularity
    wr_reg(2'd1, 8'h05);
    wr_reg(2'd0, 8'h11);
    access(20'hA0123, "R9");
    wr_reg(2'd0, 8'h13);
    access(20'hA8123, "R9");

    // R10 wrap
    wr_reg(2'd1, 8'hFF);
    wr_reg(2'd0, 8'h01);
    access(20'hAFFFF, "R10");
    access(20'hA1000, "R10");

    // R12 write takes effect on the next access
    wr_reg(2'd1, 8'h33);
    access(20'hA0010, "R12");
    wr_reg(2'd1, 8'h34);
    access(20'hA0010, "R12");
    idle();

    // R11 readback and unused select
    wr_reg(2'd2, 8'hC3);
    rd_check(2'd2, 8'hC3, "R11");
    wr_reg(2'd3, 8'h77);
    rd_check(2'd3, 8'h00, "R11");
    rd_check(2'd0, 8'h01, "R11");
    rd_check(2'd1, 8'h34, "R11");
    rd_check(2'd2, 8'hC3, "R11");
    access(20'hA0010, "R11");
    idle();

    repeat (3) @(negedge clk);
    vectors++;
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL R12: %0d results missing expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule